// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, as plain 32-bit numbers in hertz, the rates of a cascaded clock tree from the settings held in clock-control registers. Timer models and similar consumers use these numbers to know their input rate. The block generates no clocks; it only does the arithmetic.

The tree is a chain. A system PLL multiplies a 24 MHz crystal by 20 or 22. Two fractional dividers each scale the PLL rate by 18/n. A four-way source selector then feeds the bus clock. Three chained dividers of the form 1+N follow. A start pulse latches every setting and walks a state machine through the stages. All divisions share one restoring divider that yields one quotient bit per cycle. When every result is in place, the block raises done for a single cycle.

The states are:

- ST_IDLE: waiting. A start pulse latches the settings and the PLL rate, then moves to ST_FD0.
- ST_FD0: divides 18 times the PLL rate by the first fraction. It moves to ST_FD2 when the quotient is ready, or at once if the fraction is zero.
- ST_FD2: the same for the second fraction, moving to ST_AHB.
- ST_AHB: captures the selected source rate, divides it by 1+N, then moves to ST_REG.
- ST_REG: divides the AHB rate by 1+N, then moves to ST_TMR.
- ST_TMR: divides the register-bus rate by 1+N, then moves to ST_DONE.
- ST_DONE: asserts done for one cycle, then returns to ST_IDLE.

Top module: `clk_rate_calc`

## Requirements
- R1: After reset, busy, done and err are 0, and every computed rate output (pll_hz, fd0_hz, fd2_hz, periph_hz, ahb_hz, regbus_hz, tmr_hz) is 0.
- R2: pll_hz is 528,000,000 when pll_sel is 1 and 480,000,000 when pll_sel is 0.
- R3: fd0_hz and fd2_hz each equal floor(pll_hz × 18 / n), where n is fd0_den or fd2_den respectively (6-bit fields). The product is formed in 40 bits.
- R4: A fraction field of 0 gives 0 on that output and sets err.
- R5: A fractional quotient above 2^32−1 (fraction 1 or 2) saturates to 0xFFFFFFFF and sets err.
- R6: periph_hz follows src_sel: 0 gives pll_hz, 1 gives fd2_hz, 2 gives fd0_hz, 3 gives floor(fd2_hz / 2). The fd values used here are after saturation.
- R7: Each stage below the source divides the one above it by one plus its 3-bit field, with the result floored:
  - ahb_hz = floor(periph_hz / (1 + ahb_div))
  - regbus_hz = floor(ahb_hz / (1 + regbus_div))
  - tmr_hz = floor(regbus_hz / (1 + tmr_div))
- R8: done is high for exactly one cycle per calculation, and all results are valid in that cycle. busy is high from the cycle after start until done falls. A new start clears err.
- R9: Settings are captured on the start pulse. Changing the inputs, or pulsing start, while busy has no effect on the results.
- R10: xtal_hz is constantly 24,000,000 and xtal_div_hz is constantly 3,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| pll_sel | input | 1 | PLL multiplier select: 1 for ×22, 0 for ×20 |
| fd0_den | input | 6 | Fraction of fractional divider 0 |
| fd2_den | input | 6 | Fraction of fractional divider 2 |
| src_sel | input | 2 | Bus clock source select |
| ahb_div | input | 3 | AHB divider field (divides by 1+N) |
| regbus_div | input | 3 | Register-bus divider field (divides by 1+N) |
| tmr_div | input | 3 | Timer clock divider field (divides by 1+N) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero fraction or saturated quotient seen |
| pll_hz | output | 32 | System PLL rate |
| fd0_hz | output | 32 | Fractional divider 0 rate |
| fd2_hz | output | 32 | Fractional divider 2 rate |
| periph_hz | output | 32 | Selected source rate |
| ahb_hz | output | 32 | AHB rate |
| regbus_hz | output | 32 | Register-bus rate |
| tmr_hz | output | 32 | Timer clock rate |
| xtal_hz | output | 32 | Fixed crystal rate |
| xtal_div_hz | output | 32 | Crystal rate divided by 8 |

## Verification
The hardest situations to reach are the error paths. Here one fraction is zero or small enough to overflow, and the other feeds the source selector. A zero or saturated value then has to pass correctly down the chained dividers. The sweep reaches them by stepping the first fraction through all 64 values and deriving the second from it with a modular rule. This brings both to zero, one and two in different runs, under every source selection and both PLL settings. A few runs also rewrite every input and pulse start partway through a calculation, to show that the latched settings govern the results.

// File: rtl/clkcalc_pkg.sv
package clkcalc_pkg;
    localparam int unsigned REF_HZ      = 24_000_000;
    localparam int unsigned PLL_MUL_HI  = 22;
    localparam int unsigned PLL_MUL_LO  = 20;
    localparam int unsigned FD_SCALE    = 18;
    localparam int unsigned XTAL_DIVIDE = 8;
    localparam int FRAC_W = 6;
    localparam int SRC_W  = 2;
    localparam int DIVF_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FD0, ST_FD2, ST_AHB, ST_REG, ST_TMR, ST_DONE
    } calc_state_t;

    typedef struct packed {
        logic              pll_sel;
        logic [FRAC_W-1:0] fd0;
        logic [FRAC_W-1:0] fd2;
        logic [SRC_W-1:0]  src;
        logic [DIVF_W-1:0] ahb;
        logic [DIVF_W-1:0] regbus;
        logic [DIVF_W-1:0] tmr;
    } calc_cfg_t;
endpackage

// File: rtl/clkcalc_div.sv
module clkcalc_div #(
    parameter int NW = 40,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          ok,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] acc;
    logic [DW-1:0] rem;
    logic [CW-1:0] cnt;
    logic          act;
    logic [DW:0]   trial;
    logic          fits;

    // Shift in the next numerator bit and try to subtract the divisor.
    always_comb begin
        trial = {rem, acc[NW-1]};
        fits  = (trial >= {1'b0, den});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            rem <= '0;
            cnt <= '0;
            act <= 1'b0;
            ok  <= 1'b0;
        end else begin
            ok <= act && (cnt == CW'(1));
            if (go) begin
                acc <= num;
                rem <= '0;
                cnt <= CW'(NW);
                act <= 1'b1;
            end else if (act) begin
                if (fits) begin
                    rem <= DW'(trial - {1'b0, den});
                    acc <= {acc[NW-2:0], 1'b1};
                end else begin
                    rem <= trial[DW-1:0];
                    acc <= {acc[NW-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) act <= 1'b0;
            end
        end
    end

    assign quo = acc;

    // R3
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) go |-> !act);
    // R8
    ok_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n) ok |-> $past(act));
endmodule

// File: rtl/clkcalc_srcmux.sv
module clkcalc_srcmux #(
    parameter int OW = 32
) (
    input  logic [1:0]    sel,
    input  logic [OW-1:0] pll,
    input  logic [OW-1:0] fd0,
    input  logic [OW-1:0] fd2,
    output logic [OW-1:0] out
);
    always_comb begin
        unique case (sel)
            2'd0: out = pll;
            2'd1: out = fd2;
            2'd2: out = fd0;
            default: out = fd2 >> 1;
        endcase
    end
endmodule

// File: rtl/clk_rate_calc.sv
module clk_rate_calc
    import clkcalc_pkg::*;
#(
    parameter int NW = 40,
    parameter int OW = 32,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pll_sel,
    input  logic [FRAC_W-1:0] fd0_den,
    input  logic [FRAC_W-1:0] fd2_den,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic [DIVF_W-1:0] ahb_div,
    input  logic [DIVF_W-1:0] regbus_div,
    input  logic [DIVF_W-1:0] tmr_div,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [OW-1:0]     pll_hz,
    output logic [OW-1:0]     fd0_hz,
    output logic [OW-1:0]     fd2_hz,
    output logic [OW-1:0]     periph_hz,
    output logic [OW-1:0]     ahb_hz,
    output logic [OW-1:0]     regbus_hz,
    output logic [OW-1:0]     tmr_hz,
    output logic [OW-1:0]     xtal_hz,
    output logic [OW-1:0]     xtal_div_hz
);
    localparam logic [OW-1:0] PLL_HI    = OW'(REF_HZ * PLL_MUL_HI);
    localparam logic [OW-1:0] PLL_LO    = OW'(REF_HZ * PLL_MUL_LO);
    localparam logic [NW-1:0] SAT_LIMIT = {{(NW-OW){1'b0}}, {OW{1'b1}}};

    calc_state_t   state, nstate;
    calc_cfg_t     cfg;
    logic          running, div_go, div_ok, is_div, den_zero, step_done, q_over;
    logic [NW-1:0] num, div_q;
    logic [DW-1:0] den;
    logic [OW-1:0] mux_hz, res;
    logic [OW-1:0] pll_q, fd0_q, fd2_q, periph_q, ahb_q, reg_q, tmr_q;
    logic          err_q;

    clkcalc_srcmux #(.OW(OW)) u_mux (
        .sel(cfg.src), .pll(pll_q), .fd0(fd0_q), .fd2(fd2_q), .out(mux_hz)
    );

    // Numerator and divisor for the current stage.
    always_comb begin
        num = '0;
        den = '0;
        unique case (state)
            ST_FD0: begin num = NW'(pll_q) * NW'(FD_SCALE); den = DW'(cfg.fd0); end
            ST_FD2: begin num = NW'(pll_q) * NW'(FD_SCALE); den = DW'(cfg.fd2); end
            ST_AHB: begin num = NW'(mux_hz); den = DW'(cfg.ahb) + DW'(1); end
            ST_REG: begin num = NW'(ahb_q);  den = DW'(cfg.regbus) + DW'(1); end
            ST_TMR: begin num = NW'(reg_q);  den = DW'(cfg.tmr) + DW'(1); end
            default: ;
        endcase
    end

    always_comb begin
        is_div    = (state == ST_FD0) || (state == ST_FD2) || (state == ST_AHB)
                 || (state == ST_REG) || (state == ST_TMR);
        den_zero  = is_div && (den == '0);
        step_done = den_zero || (running && div_ok);
        div_go    = is_div && !running && !den_zero;
        q_over    = (div_q > SAT_LIMIT);
        res       = den_zero ? '0 : (q_over ? {OW{1'b1}} : div_q[OW-1:0]);
    end

    clkcalc_div #(.NW(NW), .DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(num), .den(den),
        .ok(div_ok), .quo(div_q)
    );

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (start) nstate = ST_FD0;
            ST_FD0:  if (step_done) nstate = ST_FD2;
            ST_FD2:  if (step_done) nstate = ST_AHB;
            ST_AHB:  if (step_done) nstate = ST_REG;
            ST_REG:  if (step_done) nstate = ST_TMR;
            ST_TMR:  if (step_done) nstate = ST_DONE;
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            running  <= 1'b0;
            err_q    <= 1'b0;
            pll_q    <= '0;
            fd0_q    <= '0;
            fd2_q    <= '0;
            periph_q <= '0;
            ahb_q    <= '0;
            reg_q    <= '0;
            tmr_q    <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                cfg   <= '{pll_sel, fd0_den, fd2_den, src_sel, ahb_div, regbus_div, tmr_div};
                pll_q <= pll_sel ? PLL_HI : PLL_LO;
                err_q <= 1'b0;
            end
            if (div_go)      running <= 1'b1;
            else if (div_ok) running <= 1'b0;
            if (state == ST_AHB) periph_q <= mux_hz;
            if (step_done) begin
                err_q <= err_q | den_zero | (!den_zero && q_over);
                unique case (state)
                    ST_FD0: fd0_q <= res;
                    ST_FD2: fd2_q <= res;
                    ST_AHB: ahb_q <= res;
                    ST_REG: reg_q <= res;
                    ST_TMR: tmr_q <= res;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        err         = err_q;
        pll_hz      = pll_q;
        fd0_hz      = fd0_q;
        fd2_hz      = fd2_q;
        periph_hz   = periph_q;
        ahb_hz      = ahb_q;
        regbus_hz   = reg_q;
        tmr_hz      = tmr_q;
        xtal_hz     = OW'(REF_HZ);
        xtal_div_hz = OW'(REF_HZ / XTAL_DIVIDE);
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R4
    zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FD0 && cfg.fd0 == '0) |=> (err_q && fd0_q == '0));
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cfg));
endmodule

// File: tb/tb_clk_rate_calc.sv
module tb_clk_rate_calc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pll_sel = 1'b0;
    logic [5:0] fd0_den = '0, fd2_den = '0;
    logic [1:0] src_sel = '0;
    logic [2:0] ahb_div = '0, regbus_div = '0, tmr_div = '0;
    logic busy, done, err;
    logic [31:0] pll_hz, fd0_hz, fd2_hz, periph_hz, ahb_hz, regbus_hz, tmr_hz, xtal_hz, xtal_div_hz;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    clk_rate_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pll_sel(pll_sel),
        .fd0_den(fd0_den), .fd2_den(fd2_den), .src_sel(src_sel),
        .ahb_div(ahb_div), .regbus_div(regbus_div), .tmr_div(tmr_div),
        .busy(busy), .done(done), .err(err), .pll_hz(pll_hz), .fd0_hz(fd0_hz),
        .fd2_hz(fd2_hz), .periph_hz(periph_hz), .ahb_hz(ahb_hz),
        .regbus_hz(regbus_hz), .tmr_hz(tmr_hz), .xtal_hz(xtal_hz),
        .xtal_div_hz(xtal_div_hz)
    );

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fd_model(input longint unsigned pll, input int f,
                            output longint unsigned q, output bit e);
        e = 1'b0;
        if (f == 0) begin
            q = 0; e = 1'b1;
        end else begin
            q = pll * 18 / f;
            if (q > 64'hFFFF_FFFF) begin q = 64'hFFFF_FFFF; e = 1'b1; end
        end
    endtask

    task automatic run(input bit p, input int f0, input int f2, input int s,
                       input int a, input int b, input int c, input bit disturb);
        longint unsigned pll, q0, q2, per, ahb, rb, tm;
        bit e0, e2;
        int n;
        @(negedge clk);
        pll_sel = p; fd0_den = 6'(f0); fd2_den = 6'(f2); src_sel = 2'(s);
        ahb_div = 3'(a); regbus_div = 3'(b); tmr_div = 3'(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", busy, 1);
        if (disturb) begin
            repeat (30) @(negedge clk);
            chk("R8 busy mid-run", busy, 1);
            pll_sel = ~p; fd0_den = ~fd0_den; fd2_den = ~fd2_den; src_sel = ~src_sel;
            ahb_div = ~ahb_div; regbus_div = ~regbus_div; tmr_div = ~tmr_div;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 1000) begin @(negedge clk); n++; end
        chk("R8 done seen", done, 1);
        pll = p ? 64'd528000000 : 64'd480000000;
        fd_model(pll, f0, q0, e0);
        fd_model(pll, f2, q2, e2);
        case (s)
            0: per = pll;
            1: per = q2;
            2: per = q0;
            default: per = q2 / 2;
        endcase
        ahb = per / (a + 1);
        rb = ahb / (b + 1);
        tm = rb / (c + 1);
        chk("R2 pll_hz", pll_hz, pll);
        chk("R3 R5 fd0_hz", fd0_hz, q0);
        chk("R3 R5 fd2_hz", fd2_hz, q2);
        chk("R4 R5 err", err, longint'(e0 | e2));
        chk("R6 periph_hz", periph_hz, per);
        chk("R7 ahb_hz", ahb_hz, ahb);
        chk("R7 regbus_hz", regbus_hz, rb);
        chk("R7 tmr_hz", tmr_hz, tm);
        if (disturb) chk("R9 settings held", tmr_hz, tm);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
        chk("R8 busy released", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 pll_hz", pll_hz, 0);
        chk("R1 fd0_hz", fd0_hz, 0);
        chk("R1 periph_hz", periph_hz, 0);
        chk("R1 tmr_hz", tmr_hz, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 fixed rates
        chk("R10 xtal_hz", xtal_hz, 24000000);
        chk("R10 xtal_div_hz", xtal_div_hz, 3000000);
        // Directed corners: zero fraction, then clean run clearing err (R8)
        run(1'b1, 0, 24, 1, 3, 1, 0, 1'b0);
        run(1'b1, 27, 24, 0, 0, 0, 0, 1'b0);
        run(1'b0, 1, 2, 2, 7, 7, 7, 1'b0);
        run(1'b0, 35, 18, 3, 1, 2, 3, 1'b1);
        for (int f = 0; f < 64; f++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p < 2; p++) begin
                    int idx;
                    idx = f * 8 + s * 2 + p;
                    run(p[0], f, (f * 37 + 11) % 64, s, idx % 8, (idx / 8) % 8,
                        (idx / 3) % 8, (idx % 97) == 5);
                end
            end
        end
        chk("R10 xtal_hz after runs", xtal_hz, 24000000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule